// File: doc/BRIEF.md
# Set-Clear GPIO Bank Register File

This block holds the control state for a set of general-purpose I/O pins, grouped thirty-two pins to a group, and exposes it on a plain 32-bit register bus. Each group has four registers. A direction register picks input or output for each pin. An output latch supplies the pin drive value. Two write-one ports raise or lower selected latch bits, so software never has to do a read-modify-write. A fourth word reads back the level on each pin after it has been synchronized to the block clock.

The groups repeat at a fixed stride in the byte address space. Words that have no register, and addresses outside every group, read as zero and ignore writes. Pin muxing, pad control and interrupt detection are left to other blocks. The synchronized input vector is brought out so that an interrupt block can reuse it without adding a second pair of synchronizer flops.

Top module: `gpio_setclr_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every direction bit reads 1 and every output-enable pin is 0, so all pins are inputs. Every output-latch bit and pin output value is 0.
- R2: A write to a group's direction word (offset 0x00) loads it. A 0 bit turns on the output enable of that pin and a 1 bit turns it off, starting at the edge that captures the write. Reading the word returns the stored value.
- R3: A write to the output-data word (offset 0x04) replaces the whole 32-bit latch of that group. The new value appears on the pin outputs and in the readback after the capturing edge.
- R4: A write to the set word (offset 0x08) forces to 1 every latch bit whose written bit is 1 and leaves the other bits as they were.
- R5: A write to the clear word (offset 0x0C) forces to 0 every latch bit whose written bit is 1 and leaves the other bits as they were.
- R6: The input-data word (offset 0x10) and the synchronized-input output both return each pin level through two flip-flop stages. A level change shows up two clock edges later, and this holds whether the pin is an input or an output.
- R7: Reading the set word or the clear word returns the current output latch of that group.
- R8: Group n, with n from 0 to NUM_GROUPS-1, starts at byte address 0x10 + 0x28*n. A write to one group leaves the registers and pins of every other group unchanged.
- R9: The following read as 0 and ignore writes: the unimplemented words at offsets 0x14 to 0x24 of each group, any address below 0x10 or at or above the end of the last group, and any address whose two low bits are not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W (8) | Byte address of the access |
| busWrEn | input | 1 | Write strobe; the data is captured at the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, valid in the same cycle |
| pinIn | input | NUM_GROUPS*32 (160) | Raw pin levels |
| pinOut | output | NUM_GROUPS*32 (160) | Pin drive values from the output latches |
| pinOe | output | NUM_GROUPS*32 (160) | Pin output enables, 1 = drive |
| syncIn | output | NUM_GROUPS*32 (160) | Pin levels after the two-stage synchronizer |

## Verification
Register writes take effect at the rising edge that samples busWrEn. The pins and the combinational readback show the new value from that edge on. The bench applies each write on a falling edge and reads back on the next falling edge, a full half period after the capture. An input level change needs two rising edges before it reaches syncIn and the input-data word. The bench changes pinIn on a falling edge and checks that the old value is still seen one cycle later and the new value two cycles later. Addresses that are not decoded are written and then read back, and the pins are inspected afterwards, so a stray write would show up in the result.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

  // Pins per register group and bus data width.
  localparam int GROUP_W      = 32;
  // Word-address layout: first group at byte 0x10, groups 0x28 bytes apart.
  localparam int FIRST_WORD   = 4;
  localparam int STRIDE_WORDS = 10;
  localparam int GROUP_WORDS  = 10;
  // Width of the group index carried in the strobe bundle.
  localparam int GRP_W        = 8;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_OUT  = 3'd2,
    SEL_SET  = 3'd3,
    SEL_CLR  = 3'd4,
    SEL_IN   = 3'd5
  } regSel_e;

  // Decoded access handed from control to datapath.
  typedef struct packed {
    logic             hit;
    logic [GRP_W-1:0] grp;
    regSel_e          sel;
    logic             dirWr;
    logic             outWr;
    logic             setWr;
    logic             clrWr;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int ADDR_W     = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strobe
);

  logic [31:0] wordAddr;
  assign wordAddr = 32'(busAddr[ADDR_W-1:2]);

  always_comb begin
    strobe     = '0;
    strobe.sel = SEL_NONE;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int r = 0; r < GROUP_WORDS; r++) begin
        if (busAddr[1:0] == 2'b00 &&
            wordAddr == 32'(FIRST_WORD + STRIDE_WORDS * g + r)) begin
          strobe.hit = 1'b1;
          strobe.grp = GRP_W'(g);
          case (r)
            0: begin strobe.sel = SEL_DIR; strobe.dirWr = busWrEn; end
            1: begin strobe.sel = SEL_OUT; strobe.outWr = busWrEn; end
            2: begin strobe.sel = SEL_SET; strobe.setWr = busWrEn; end
            3: begin strobe.sel = SEL_CLR; strobe.clrWr = busWrEn; end
            4: strobe.sel = SEL_IN;
            default: strobe.sel = SEL_NONE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/gpio_setclr_dpath.sv
module gpio_setclr_dpath
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  localparam int PIN_W     = NUM_GROUPS * GROUP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [GROUP_W-1:0] busWrData,
  output logic [GROUP_W-1:0] busRdData,
  input  logic [PIN_W-1:0]   pinIn,
  output logic [PIN_W-1:0]   pinOut,
  output logic [PIN_W-1:0]   pinOe,
  output logic [PIN_W-1:0]   syncIn
);

  logic [GROUP_W-1:0] dirQ [NUM_GROUPS];
  logic [GROUP_W-1:0] outQ [NUM_GROUPS];
  logic [PIN_W-1:0]   syncMeta;
  logic [PIN_W-1:0]   syncQ;

  // Two-stage input synchronizer shared by readback and syncIn.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= '0;
      syncQ    <= '0;
    end else begin
      syncMeta <= pinIn;
      syncQ    <= syncMeta;
    end
  end
  assign syncIn = syncQ;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_group
    logic grpHit;
    assign grpHit = strobe.hit && (strobe.grp == GRP_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ[g] <= '1;
        outQ[g] <= '0;
      end else if (grpHit) begin
        if (strobe.dirWr) dirQ[g] <= busWrData;
        if (strobe.outWr)      outQ[g] <= busWrData;
        else if (strobe.setWr) outQ[g] <= outQ[g] | busWrData;
        else if (strobe.clrWr) outQ[g] <= outQ[g] & ~busWrData;
      end
    end

    assign pinOe[g*GROUP_W +: GROUP_W]  = ~dirQ[g];
    assign pinOut[g*GROUP_W +: GROUP_W] = outQ[g];
  end

  always_comb begin
    busRdData = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (strobe.hit && strobe.grp == GRP_W'(g)) begin
        case (strobe.sel)
          SEL_DIR:                   busRdData = dirQ[g];
          SEL_OUT, SEL_SET, SEL_CLR: busRdData = outQ[g];
          SEL_IN:                    busRdData = syncQ[g*GROUP_W +: GROUP_W];
          default:                   busRdData = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int ADDR_W     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWrEn,
  input  logic [31:0]                   busWrData,
  output logic [31:0]                   busRdData,
  input  logic [NUM_GROUPS*GROUP_W-1:0] pinIn,
  output logic [NUM_GROUPS*GROUP_W-1:0] pinOut,
  output logic [NUM_GROUPS*GROUP_W-1:0] pinOe,
  output logic [NUM_GROUPS*GROUP_W-1:0] syncIn
);

  ctrlStrobe_t strobe;

  gpio_setclr_ctrl #(
    .NUM_GROUPS(NUM_GROUPS),
    .ADDR_W    (ADDR_W)
  ) i_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  gpio_setclr_dpath #(
    .NUM_GROUPS(NUM_GROUPS)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .syncIn   (syncIn)
  );

endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_GROUPS = 5,
  parameter int ADDR_W     = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             busAddr,
  input logic                          busWrEn,
  input logic [31:0]                   busWrData,
  input logic [31:0]                   busRdData,
  input logic [NUM_GROUPS*GROUP_W-1:0] pinIn,
  input logic [NUM_GROUPS*GROUP_W-1:0] pinOut,
  input logic [NUM_GROUPS*GROUP_W-1:0] pinOe,
  input logic [NUM_GROUPS*GROUP_W-1:0] syncIn
);

  localparam logic [ADDR_W-1:0] G0_DIR = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] G0_SET = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] G0_CLR = ADDR_W'(8'h1C);

  // Edges seen since reset release, saturating at 2.
  logic [1:0] edgesSinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgesSinceRst <= '0;
    else if (edgesSinceRst != 2'd2) edgesSinceRst <= edgesSinceRst + 2'd1;
  end

  AST_RESET_ALL_INPUT: assert property (@(posedge clk)
    !rstN |=> (pinOe == '0 && pinOut == '0)); // R1

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == G0_DIR |-> busRdData == ~pinOe[GROUP_W-1:0]); // R2

  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == G0_SET) |=>
      pinOut[GROUP_W-1:0] == ($past(pinOut[GROUP_W-1:0]) | $past(busWrData))); // R4

  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == G0_CLR) |=>
      pinOut[GROUP_W-1:0] == ($past(pinOut[GROUP_W-1:0]) & ~$past(busWrData))); // R5

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    edgesSinceRst == 2'd2 |-> syncIn == $past(pinIn, 2)); // R6

  AST_UNDECODED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr < G0_DIR || busAddr[1:0] != 2'b00)) |=>
      ($stable(pinOut) && $stable(pinOe))); // R9

  AST_UNDECODED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < G0_DIR || busAddr[1:0] != 2'b00) |-> busRdData == '0); // R9

endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .ADDR_W    (ADDR_W)
) i_chk (.*);

// File: tb/test_gpio_setclr_bank.sv
module test_gpio_setclr_bank;

  localparam int NUM_GROUPS = 5;
  localparam int ADDR_W     = 8;
  localparam int PIN_W      = NUM_GROUPS * 32;
  localparam int HALF       = 4; // 8-unit period, 125 MHz

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [PIN_W-1:0]  pinIn = '0;
  logic [PIN_W-1:0]  pinOut;
  logic [PIN_W-1:0]  pinOe;
  logic [PIN_W-1:0]  syncIn;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #HALF clk = ~clk;

  gpio_setclr_bank #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) i_gpio_setclr_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .syncIn(syncIn)
  );

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWrEn = 1'b0;
    #1;
    data = busRdData;
  endtask

  typedef struct packed {
    logic [7:0]  wrAddr;
    logic [31:0] wrData;
    logic [7:0]  rdAddr;
    logic [31:0] expRd;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{8'h14, 32'hA5A5_0F0F, 8'h14, 32'hA5A5_0F0F, 4'd3}, // R3 load latch
    '{8'h18, 32'h0000_00F0, 8'h14, 32'hA5A5_0FFF, 4'd4}, // R4 set ones
    '{8'h1C, 32'hA000_000F, 8'h14, 32'h05A5_0FF0, 4'd5}, // R5 clear ones
    '{8'h18, 32'h0000_0000, 8'h18, 32'h05A5_0FF0, 4'd7}, // R4 zero set, R7 read set word
    '{8'h1C, 32'h0000_0000, 8'h1C, 32'h05A5_0FF0, 4'd7}, // R5 zero clear, R7 read clear word
    '{8'h10, 32'hFFFF_0000, 8'h10, 32'hFFFF_0000, 4'd2}, // R2 direction
    '{8'h3C, 32'h1234_5678, 8'h3C, 32'h1234_5678, 4'd8}, // R8 group 1
    '{8'hB4, 32'hDEAD_BEEF, 8'hB4, 32'hDEAD_BEEF, 4'd8}, // R8 group 4
    '{8'hB8, 32'h0000_0010, 8'h14, 32'h05A5_0FF0, 4'd8}, // R8 other group untouched
    '{8'h24, 32'hFFFF_FFFF, 8'h24, 32'h0000_0000, 4'd9}, // R9 unimplemented word
    '{8'h08, 32'hFFFF_FFFF, 8'h08, 32'h0000_0000, 4'd9}, // R9 below first group
    '{8'hD8, 32'hFFFF_FFFF, 8'hD8, 32'h0000_0000, 4'd9}, // R9 past last group
    '{8'h15, 32'hFFFF_FFFF, 8'h14, 32'h05A5_0FF0, 4'd9}, // R9 unaligned write ignored
    '{8'h38, 32'h0000_0000, 8'h38, 32'h0000_0000, 4'd2}  // R2 group 1 all outputs
  };

  initial begin
    logic [31:0] rd;
    // R1: state during and after reset
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pinOe[31:0], 32'h0);
    check("R1 out in reset", pinOut[159:128], 32'h0);
    rstN = 1'b1;
    busRead(8'h10, rd); check("R1 dir g0", rd, 32'hFFFF_FFFF);
    busRead(8'hB0, rd); check("R1 dir g4", rd, 32'hFFFF_FFFF);
    busRead(8'h14, rd); check("R1 latch g0", rd, 32'h0);
    check("R1 oe g4", pinOe[159:128], 32'h0);

    foreach (VECS[i]) begin
      busWrite(VECS[i].wrAddr, VECS[i].wrData);
      busRead(VECS[i].rdAddr, rd);
      check($sformatf("table row %0d (R%0d)", i, VECS[i].req), rd, VECS[i].expRd);
    end

    check("R2 oe g0", pinOe[31:0], 32'h0000_FFFF);
    check("R2 oe g1", pinOe[63:32], 32'hFFFF_FFFF);
    check("R3 pins g0", pinOut[31:0], 32'h05A5_0FF0);
    check("R8 pins g4", pinOut[159:128], 32'hDEAD_BEFF);
    check("R9 pins g2 untouched", pinOut[95:64], 32'h0);
    check("R9 oe g2 untouched", pinOe[95:64], 32'h0);

    // R6: two-edge latency on an input group
    @(negedge clk);
    pinIn[159:128] = 32'h55AA_33CC;
    busRead(8'hC0, rd); check("R6 one edge still old", rd, 32'h0);
    busRead(8'hC0, rd); check("R6 two edges new", rd, 32'h55AA_33CC);
    check("R6 syncIn out", syncIn[159:128], 32'h55AA_33CC);

    // R6: level on pins configured as outputs is still returned
    @(negedge clk);
    pinIn[31:0] = 32'h0000_BEEF;
    busRead(8'h20, rd);
    busRead(8'h20, rd); check("R6 output pin readback", rd, 32'h0000_BEEF);

    // R1: reset mid-run returns everything to inputs and clears latches
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 oe after mid reset", pinOe[31:0], 32'h0);
    check("R1 out after mid reset", pinOut[159:128], 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    busRead(8'h38, rd); check("R1 dir g1 after mid reset", rd, 32'hFFFF_FFFF);

    finishRun();
  end

endmodule